// File: doc/BRIEF.md
# Two-Window Peripheral Wait-State Controller

This block stretches peripheral bus accesses by a programmable number of cycles. Two address windows each carry their own 3-bit timing setting. A requester (CPU or DMA) presents an access with a window select, a width (16 or 32 bits) and a flag marking it as a sequential burst unit. The controller accepts the access, pulses a peripheral strobe at the start of each 16-bit half, and holds `ready` low until the final cycle. A 32-bit access always runs as two 16-bit halves. On the final cycle it reports how many cycles the access took.

For a non-sequential access, the low two bits of the window's setting pick the first-half time. Bit 2 picks the cost of any later 16-bit half. The slow second-half cost differs between the two windows, while the fast one is shared. A sequential unit never pays the first-access time, so every half it runs costs the later-half time. Settings are sampled only when an access is accepted.

Top module: `wsc_bus_ctrl`

## Requirements
- R1: After reset `ready` is 1 and `periph_strobe` and `done` are 0.
- R2: A non-sequential 16-bit access lasts 10, 8, 6 or 18 cycles for setting bits [1:0] = 0, 1, 2, 3 in either window.
- R3: A non-sequential 32-bit access in window 0 (`req_win`=0) lasts the R2 time plus 6 cycles when setting bit 2 is 0, or plus 4 cycles when bit 2 is 1.
- R4: A non-sequential 32-bit access in window 1 (`req_win`=1) lasts the R2 time plus 10 cycles when setting bit 2 is 0, or plus 4 cycles when bit 2 is 1.
- R5: A sequential 16-bit access (`req_seq`=1, `req_wide`=0) lasts 6 cycles in window 0 and 10 cycles in window 1 when bit 2 is 0, and 4 cycles in either window when bit 2 is 1. Bits [1:0] have no effect on it.
- R6: A sequential 32-bit access lasts exactly twice the R5 time for the same window and setting.
- R7: The setting used for an access is the one present on the cycle it is accepted. Changing a setting during an access leaves that access's length unchanged, and the change applies from the next access.
- R8: An access is accepted on a rising edge where `req_valid` and `ready` are both 1. `ready` is 0 in every cycle after that up to, but not including, the final cycle, so an access of N cycles shows N-1 cycles of `ready` low.
- R9: `periph_strobe` is a one-cycle pulse in the first cycle of each half, so a 16-bit access gives one pulse and a 32-bit access gives two. `periph_half` is 0 during the first half and 1 during the second.
- R10: `done` is 1 only in the final cycle of an access, and in that cycle `done_cycles` equals the access length in cycles.
- R11: A request presented in the final cycle of an access is accepted on that edge, so the next access starts with no idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_win0 | input | 3 | Timing setting of window 0 |
| cfg_win1 | input | 3 | Timing setting of window 1 |
| req_valid | input | 1 | Access request |
| req_win | input | 1 | Window select: 0 or 1 |
| req_wide | input | 1 | 1 = 32-bit access, 0 = 16-bit |
| req_seq | input | 1 | 1 = sequential burst unit |
| ready | output | 1 | High when idle or in the final cycle of an access |
| periph_strobe | output | 1 | Pulse at the start of each 16-bit half |
| periph_half | output | 1 | Index of the half now in progress |
| done | output | 1 | Final-cycle marker |
| done_cycles | output | 8 | Length of the finishing access |

## Verification
The bench covers all eight settings in both windows, for every combination of width and sequential flag. A design that used the wrong slow second-half cost in window 1, or that let bits [1:0] reach sequential units, would report lengths that do not match. A setting is changed in the middle of a 32-bit access, which exposes a design that reads the live setting when the second half begins. Requests issued on the final cycle check that back-to-back accesses start with no idle cycle. The bench also counts strobe pulses and ready-low cycles per access, which catches an off-by-one at the half boundary.

// File: rtl/wsc_pkg.sv
package wsc_pkg;
   localparam int CFG_W   = 3;
   localparam int NUM_WIN = 2;

   typedef struct packed {
      logic win;
      logic wide;
      logic seq;
   } wsc_req_t;
endpackage

// File: rtl/wsc_cfg_latch.sv
module wsc_cfg_latch
   import wsc_pkg::*;
#(
   parameter int N_WIN = NUM_WIN
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        load,
   input  logic [N_WIN-1:0][CFG_W-1:0] cfg_in,
   output logic [N_WIN-1:0][CFG_W-1:0] cfg_q
);
   for (genvar w = 0; w < N_WIN; w++) begin : g_win
      always_ff @(posedge clk) begin
         if (!rst_n)
            cfg_q[w] <= '0;
         else if (load)
            cfg_q[w] <= cfg_in[w];
      end
   end
endmodule

// File: rtl/wsc_timing.sv
module wsc_timing
   import wsc_pkg::*;
#(
   parameter int CNT_W  = 8,
   parameter int BASE_0 = 10,
   parameter int BASE_1 = 8,
   parameter int BASE_2 = 6,
   parameter int BASE_3 = 18,
   parameter int SLOW_0 = 6,
   parameter int SLOW_1 = 10,
   parameter int FAST   = 4
) (
   input  logic [CFG_W-1:0] cfg,
   input  logic             win,
   input  logic             seq,
   output logic [CNT_W-1:0] first_len,
   output logic [CNT_W-1:0] ext_len
);
   localparam int SLOW_TAB [NUM_WIN] = '{SLOW_0, SLOW_1};

   logic [NUM_WIN-1:0][CNT_W-1:0] slow_len;
   logic [CNT_W-1:0]              base_len;

   for (genvar w = 0; w < NUM_WIN; w++) begin : g_slow
      assign slow_len[w] = CNT_W'(SLOW_TAB[w]);
   end

   always_comb begin
      unique case (cfg[1:0])
         2'd0:    base_len = CNT_W'(BASE_0);
         2'd1:    base_len = CNT_W'(BASE_1);
         2'd2:    base_len = CNT_W'(BASE_2);
         default: base_len = CNT_W'(BASE_3);
      endcase
   end

   assign ext_len   = cfg[2] ? CNT_W'(FAST) : slow_len[win];
   assign first_len = seq ? ext_len : base_len;
endmodule

// File: rtl/wsc_sequencer.sv
module wsc_sequencer
   import wsc_pkg::*;
#(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   input  wsc_req_t         req,
   input  logic [CNT_W-1:0] h1_len,
   input  logic [CNT_W-1:0] h2_len,
   output wsc_req_t         req_q,
   output logic             accept,
   output logic             ready,
   output logic             strobe,
   output logic             half,
   output logic             done,
   output logic [CNT_W-1:0] elapsed
);
   logic             busy;
   logic [CNT_W-1:0] left;
   logic             half_end;

   assign half_end = busy && (left == CNT_W'(1));
   assign done     = half_end && (half || !req_q.wide);
   assign ready    = !busy || done;
   assign accept   = req_valid && ready;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy    <= 1'b0;
         half    <= 1'b0;
         left    <= '0;
         elapsed <= '0;
         strobe  <= 1'b0;
         req_q   <= '0;
      end else begin
         strobe <= 1'b0;
         if (accept) begin
            busy    <= 1'b1;
            half    <= 1'b0;
            left    <= h1_len;
            elapsed <= CNT_W'(1);
            strobe  <= 1'b1;
            req_q   <= req;
         end else if (half_end) begin
            if (!half && req_q.wide) begin
               half    <= 1'b1;
               left    <= h2_len;
               strobe  <= 1'b1;
               elapsed <= elapsed + CNT_W'(1);
            end else begin
               busy <= 1'b0;
               half <= 1'b0;
            end
         end else if (busy) begin
            left    <= left - CNT_W'(1);
            elapsed <= elapsed + CNT_W'(1);
         end
      end
   end
endmodule

// File: rtl/wsc_bus_ctrl.sv
module wsc_bus_ctrl
   import wsc_pkg::*;
#(
   parameter int CNT_W  = 8,
   parameter int BASE_0 = 10,
   parameter int BASE_1 = 8,
   parameter int BASE_2 = 6,
   parameter int BASE_3 = 18,
   parameter int SLOW_0 = 6,
   parameter int SLOW_1 = 10,
   parameter int FAST   = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [2:0]       cfg_win0,
   input  logic [2:0]       cfg_win1,
   input  logic             req_valid,
   input  logic             req_win,
   input  logic             req_wide,
   input  logic             req_seq,
   output logic             ready,
   output logic             periph_strobe,
   output logic             periph_half,
   output logic             done,
   output logic [CNT_W-1:0] done_cycles
);
   localparam int MAX_BASE = (BASE_0 > BASE_1 ? BASE_0 : BASE_1) > (BASE_2 > BASE_3 ? BASE_2 : BASE_3)
                           ? (BASE_0 > BASE_1 ? BASE_0 : BASE_1) : (BASE_2 > BASE_3 ? BASE_2 : BASE_3);
   localparam int MAX_EXT  = (SLOW_0 > SLOW_1 ? SLOW_0 : SLOW_1) > FAST
                           ? (SLOW_0 > SLOW_1 ? SLOW_0 : SLOW_1) : FAST;
   localparam int MIN_ALL  = 2;

   if (MAX_BASE + MAX_EXT >= (1 << CNT_W)) begin : g_chk_w
      $error("CNT_W too narrow for the longest access");
   end
   if (BASE_0 < MIN_ALL || BASE_1 < MIN_ALL || BASE_2 < MIN_ALL || BASE_3 < MIN_ALL ||
       SLOW_0 < MIN_ALL || SLOW_1 < MIN_ALL || FAST < MIN_ALL) begin : g_chk_min
      $error("every half must last at least two cycles");
   end

   logic [NUM_WIN-1:0][CFG_W-1:0] cfg_live;
   logic [NUM_WIN-1:0][CFG_W-1:0] cfg_q;
   wsc_req_t                      req_in;
   wsc_req_t                      req_q;
   logic                          accept;
   logic [CNT_W-1:0]              h1_len;
   logic [CNT_W-1:0]              h2_len;
   logic [CNT_W-1:0]              unused_ext;
   logic [CNT_W-1:0]              unused_first;
   logic [CNT_W-1:0]              elapsed;

   assign cfg_live = {cfg_win1, cfg_win0};
   assign req_in   = '{win: req_win, wide: req_wide, seq: req_seq};

   wsc_cfg_latch #(.N_WIN(NUM_WIN)) u_cfg (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (accept),
      .cfg_in (cfg_live),
      .cfg_q  (cfg_q)
   );

   wsc_timing #(
      .CNT_W(CNT_W), .BASE_0(BASE_0), .BASE_1(BASE_1), .BASE_2(BASE_2), .BASE_3(BASE_3),
      .SLOW_0(SLOW_0), .SLOW_1(SLOW_1), .FAST(FAST)
   ) u_time_new (
      .cfg       (cfg_live[req_win]),
      .win       (req_win),
      .seq       (req_seq),
      .first_len (h1_len),
      .ext_len   (unused_ext)
   );

   wsc_timing #(
      .CNT_W(CNT_W), .BASE_0(BASE_0), .BASE_1(BASE_1), .BASE_2(BASE_2), .BASE_3(BASE_3),
      .SLOW_0(SLOW_0), .SLOW_1(SLOW_1), .FAST(FAST)
   ) u_time_cur (
      .cfg       (cfg_q[req_q.win]),
      .win       (req_q.win),
      .seq       (req_q.seq),
      .first_len (unused_first),
      .ext_len   (h2_len)
   );

   wsc_sequencer #(.CNT_W(CNT_W)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .req       (req_in),
      .h1_len    (h1_len),
      .h2_len    (h2_len),
      .req_q     (req_q),
      .accept    (accept),
      .ready     (ready),
      .strobe    (periph_strobe),
      .half      (periph_half),
      .done      (done),
      .elapsed   (elapsed)
   );

   assign done_cycles = done ? elapsed : '0;
endmodule

// File: rtl/wsc_bus_ctrl_chk.sv
module wsc_bus_ctrl_chk #(
   parameter int CNT_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             req_valid,
   input logic             ready,
   input logic             periph_strobe,
   input logic             periph_half,
   input logic             done,
   input logic [CNT_W-1:0] done_cycles,
   input logic [5:0]       cfg_lat
);
   assert_accept_drops_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && ready) |=> !ready);

   assert_strobe_in_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
      periph_strobe |-> !ready);

   assert_half_rise_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(periph_half) |-> periph_strobe);

   assert_done_ready_R10: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (ready && done_cycles != '0));

   assert_cfg_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!ready && $past(!ready)) |-> $stable(cfg_lat));
endmodule

bind wsc_bus_ctrl wsc_bus_ctrl_chk #(.CNT_W(CNT_W)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .req_valid     (req_valid),
   .ready         (ready),
   .periph_strobe (periph_strobe),
   .periph_half   (periph_half),
   .done          (done),
   .done_cycles   (done_cycles),
   .cfg_lat       (cfg_q)
);

// File: tb/wsc_bus_ctrl_tb.sv
module wsc_bus_ctrl_tb_top;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] cfg_win0 = '0;
   logic [2:0] cfg_win1 = '0;
   logic       req_valid = 1'b0;
   logic       req_win = 1'b0;
   logic       req_wide = 1'b0;
   logic       req_seq = 1'b0;
   logic       ready, periph_strobe, periph_half, done;
   logic [7:0] done_cycles;

   int vectors = 0;
   int errors  = 0;
   int edge_cnt = 0;
   bit finished = 0;

   typedef struct {
      int len;
      int accept_edge;
      bit wide;
      string tag;
   } item_t;
   item_t exp_q[$];

   always #(CLK_PERIOD/2) clk = ~clk;
   always @(posedge clk) edge_cnt <= edge_cnt + 1;

   wsc_bus_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_win0(cfg_win0), .cfg_win1(cfg_win1),
      .req_valid(req_valid), .req_win(req_win), .req_wide(req_wide), .req_seq(req_seq),
      .ready(ready), .periph_strobe(periph_strobe), .periph_half(periph_half),
      .done(done), .done_cycles(done_cycles)
   );

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      vectors++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   function automatic int exp_len(input bit [2:0] c, input bit win, input bit wide, input bit seq);
      int base, later;
      case (c[1:0])
         2'd0: base = 10;
         2'd1: base = 8;
         2'd2: base = 6;
         default: base = 18;
      endcase
      if (c[2]) later = 4;
      else later = win ? 10 : 6;
      if (seq) return wide ? 2 * later : later;
      return wide ? base + later : base;
   endfunction

   function automatic string tag_of(input bit win, input bit wide, input bit seq);
      if (seq) return wide ? "R6" : "R5";
      if (!wide) return "R2";
      return win ? "R4" : "R3";
   endfunction

   // called at a negedge; returns in the first cycle of the access
   task automatic issue(input bit win, input bit wide, input bit seq, input int len, input string tag);
      item_t it;
      while (!ready) @(negedge clk);
      req_valid = 1'b1;
      req_win   = win;
      req_wide  = wide;
      req_seq   = seq;
      it.len = len;
      it.accept_edge = edge_cnt + 1;
      it.wide = wide;
      it.tag = tag;
      exp_q.push_back(it);
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   // monitor
   int lows = 0;
   int strobes = 0;
   always @(negedge clk) begin
      if (rst_n) begin
         if (periph_strobe) begin
            check(periph_half == (strobes == 1), "R9 half index", periph_half, strobes == 1);
            strobes = strobes + 1;
         end
         if (!ready) lows = lows + 1;
         if (done) begin
            if (exp_q.size() == 0) begin
               check(0, "R10 unexpected done", 1, 0);
            end else begin
               item_t it;
               it = exp_q.pop_front();
               check(done_cycles == it.len, {it.tag, " done_cycles R10"}, done_cycles, it.len);
               check(lows == it.len - 1, "R8 ready-low cycles", lows, it.len - 1);
               check(strobes == (it.wide ? 2 : 1), "R9 strobe count", strobes, it.wide ? 2 : 1);
               check(edge_cnt - it.accept_edge == it.len - 1, "R11 latency from request",
                     edge_cnt - it.accept_edge, it.len - 1);
            end
            lows = 0;
            strobes = 0;
         end
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check(ready == 1'b1, "R1 ready", ready, 1);
      check(periph_strobe == 1'b0, "R1 strobe", periph_strobe, 0);
      check(done == 1'b0, "R1 done", done, 0);

      // R2..R6 full sweep, back-to-back (R11)
      for (int w = 0; w < 2; w++) begin
         for (int c = 0; c < 8; c++) begin
            for (int m = 0; m < 4; m++) begin
               bit wide = m[0];
               bit seq  = m[1];
               if (w == 0) cfg_win0 = 3'(c); else cfg_win1 = 3'(c);
               issue(w[0], wide, seq, exp_len(3'(c), w[0], wide, seq), tag_of(w[0], wide, seq));
            end
         end
      end

      // R7: change setting mid-access
      while (!ready) @(negedge clk);
      @(negedge clk);
      cfg_win0 = 3'd0;
      issue(1'b0, 1'b1, 1'b0, 16, "R7 old setting");
      repeat (3) @(negedge clk);
      cfg_win0 = 3'd4;
      issue(1'b0, 1'b1, 1'b0, 14, "R7 new setting");
      cfg_win1 = 3'd3;
      issue(1'b1, 1'b1, 1'b0, 28, "R7 window1");
      cfg_win1 = 3'd6;
      // R5: bits [1:0] ignored for sequential
      cfg_win1 = 3'd3;
      issue(1'b1, 1'b0, 1'b1, 10, "R5 bits ignored");

      while (exp_q.size() != 0) @(negedge clk);
      repeat (2) @(negedge clk);
      check(ready == 1'b1 && done == 1'b0, "R8 idle after last", ready, 1);
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         vectors++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
         $finish;
      end
   end
endmodule